// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Wakeup Arbitration

This block moves a microcontroller between run mode and three low-power modes: doze, wait and stop. Software first programs a two-bit mode field. The core then raises a one-cycle stop event. At that point the sequencer enters whichever mode the field holds and lowers the enables (clock-gate controls) of the modules that must sleep in that mode.

A permitted wakeup source returns the chip to run mode. Which sources are permitted depends on the mode in force. Any of the following ends a low-power period:
- a wake request from a source that the current mode allows;
- a reset request;
- the external debug breakpoint input.

On exit, every enable comes back in the same cycle that the core-run output rises. A one-cycle pulse reports the cause that was accepted.

Software disable bits, one for each module, hold a module off in every mode. A module held off in this way cannot wake the core.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, coreRun is 1, curMode is 00, wakeCause is 000 and every modEn bit is 1 while swDisable is zero.
- R2: A stopEvt pulse in run mode enters the mode held in the field (01 doze, 10 wait, 11 stop). curMode shows that value and coreRun is 0 from the next cycle on. With the field at 00, stopEvt is ignored.
- R3: In doze and wait, modEn bits 0 (core), 1 (SRAM) and 2 (flash) are 0. Bits 3 (system integration), 4 (memory controller), 5 (chip select), 6 (DMA), 7 (serial), 8 (timer), 9 (Ethernet), 10 (interrupt controller), 11 (I/O ports) and 12 (reset controller) stay 1.
- R4: In stop, only modEn bits 10, 11 and 12 are 1.
- R5: In doze and wait, a wakeReq on bit 3, 6, 7, 8, 9 or 10 ends the low-power mode. A wakeReq on bit 4, 5 or 11 does not.
- R6: In stop, only wakeReq bit 10 or rstReq ends the low-power mode. The other wakeReq bits have no effect.
- R7: bkptIn ends any low-power mode.
- R8: A set swDisable bit forces the matching modEn bit to 0 in every mode, run included. Such a module's wakeReq is ignored.
- R9: The cycle after a wake is accepted, coreRun is 1, modEn returns to its run value, and wakeCause pulses for exactly one cycle. The encoding is bit 0 interrupt, bit 1 reset and bit 2 breakpoint, with priority reset, then breakpoint, then interrupt.
- R10: A wake source that is valid for the selected mode and arrives in the same cycle as stopEvt keeps the block in run mode, and no wakeCause pulse is produced.
- R11: The mode field loads from modeWrData when modeWrEn is 1 and holds otherwise. A write made during a low-power mode does not change the mode in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeWrEn | input | 1 | Load strobe for the mode field |
| modeWrData | input | 2 | New mode field value |
| stopEvt | input | 1 | One-cycle stop event from the core |
| wakeReq | input | 13 | Per-module wake requests, same bit positions as modEn |
| rstReq | input | 1 | Reset request from the reset controller |
| bkptIn | input | 1 | External debug breakpoint |
| swDisable | input | 13 | Per-module software disable |
| modEn | output | 13 | Per-module clock enables |
| coreRun | output | 1 | 1 when the core runs |
| curMode | output | 2 | Mode in force (00 in run) |
| wakeCause | output | 3 | One-cycle wake cause pulse |

## Verification
The bench raises wake requests from sources that the current mode does not allow, such as the memory controller in wait or the timer in stop. A design with a wrong wake table would leave the low-power mode early. It fires several causes together, because a design with the wrong priority would report the interrupt instead of the reset or the breakpoint. A wake that coincides with stopEvt must leave the block in run mode with no cause pulse; a design that let the stop event win would strand the core asleep. A write to the mode field during stop, and a wake on a software-disabled source, must change nothing.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int NUM_MOD = 13;
  localparam int MODE_W  = 2;
  localparam int CAUSE_W = 3;

  localparam int IDX_CORE  = 0;
  localparam int IDX_SRAM  = 1;
  localparam int IDX_FLASH = 2;
  localparam int IDX_SYS   = 3;
  localparam int IDX_MEMC  = 4;
  localparam int IDX_CSEL  = 5;
  localparam int IDX_DMA   = 6;
  localparam int IDX_SER   = 7;
  localparam int IDX_TMR   = 8;
  localparam int IDX_ETH   = 9;
  localparam int IDX_INTC  = 10;
  localparam int IDX_IO    = 11;
  localparam int IDX_RST   = 12;

  typedef logic [NUM_MOD-1:0] modVec_t;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN  = 2'b00,
    MODE_DOZE = 2'b01,
    MODE_WAIT = 2'b10,
    MODE_STOP = 2'b11
  } pwrMode_e;

  // cause bit 0 interrupt, bit 1 reset, bit 2 breakpoint
  typedef struct packed {
    logic               enter;
    logic               exitLow;
    logic [CAUSE_W-1:0] cause;
  } ctlStrobe_t;

  function automatic modVec_t enableMask(pwrMode_e m);
    modVec_t v;
    v = '1;
    case (m)
      MODE_DOZE, MODE_WAIT: begin
        v[IDX_CORE]  = 1'b0;
        v[IDX_SRAM]  = 1'b0;
        v[IDX_FLASH] = 1'b0;
      end
      MODE_STOP: begin
        v = '0;
        v[IDX_INTC] = 1'b1;
        v[IDX_IO]   = 1'b1;
        v[IDX_RST]  = 1'b1;
      end
      default: ;
    endcase
    return v;
  endfunction

  function automatic modVec_t wakeMask(pwrMode_e m);
    modVec_t v;
    v = '0;
    case (m)
      MODE_DOZE, MODE_WAIT: begin
        v[IDX_SYS]  = 1'b1;
        v[IDX_DMA]  = 1'b1;
        v[IDX_SER]  = 1'b1;
        v[IDX_TMR]  = 1'b1;
        v[IDX_ETH]  = 1'b1;
        v[IDX_INTC] = 1'b1;
      end
      MODE_STOP: v[IDX_INTC] = 1'b1;
      default: ;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stopEvt,
  input  logic       pendRun,
  input  logic       irqHit,
  input  logic       rstReq,
  input  logic       bkptIn,
  output ctlStrobe_t strobe,
  output logic       lowNow
);
  logic wakeAny;
  logic [CAUSE_W-1:0] causeSel;

  assign wakeAny = irqHit | rstReq | bkptIn;

  always_comb begin
    if (rstReq)      causeSel = 3'b010;
    else if (bkptIn) causeSel = 3'b100;
    else if (irqHit) causeSel = 3'b001;
    else             causeSel = 3'b000;
  end

  always_comb begin
    strobe.enter   = !lowNow && stopEvt && !pendRun && !wakeAny;
    strobe.exitLow = lowNow && wakeAny;
    strobe.cause   = (lowNow && wakeAny) ? causeSel : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lowNow <= 1'b0;
    else if (strobe.enter)   lowNow <= 1'b1;
    else if (strobe.exitLow) lowNow <= 1'b0;
  end

  assert_bkpt_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    lowNow && bkptIn |=> !lowNow);

  assert_null_mode_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lowNow && pendRun |=> !lowNow);

  assert_entry_race_R10: assert property (@(posedge clk) disable iff (!rstN)
    !lowNow && wakeAny |=> !lowNow);
endmodule

// File: rtl/pwr_mode_dp.sv
module pwr_mode_dp
  import pwr_mode_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeWrEn,
  input  logic [MODE_W-1:0]  modeWrData,
  input  modVec_t            wakeReq,
  input  modVec_t            swDisable,
  input  ctlStrobe_t         strobe,
  output logic               irqHit,
  output logic               pendRun,
  output modVec_t            modEn,
  output logic [MODE_W-1:0]  curMode,
  output logic [CAUSE_W-1:0] wakeCause
);
  localparam modVec_t STOP_KEEP = modVec_t'((1 << IDX_INTC) | (1 << IDX_IO) | (1 << IDX_RST));

  pwrMode_e modeReg;
  pwrMode_e activeMode;
  pwrMode_e evalMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         modeReg <= MODE_RUN;
    else if (modeWrEn) modeReg <= pwrMode_e'(modeWrData);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMode <= MODE_RUN;
      wakeCause  <= '0;
    end else begin
      if (strobe.enter)        activeMode <= modeReg;
      else if (strobe.exitLow) activeMode <= MODE_RUN;
      wakeCause <= strobe.exitLow ? strobe.cause : '0;
    end
  end

  assign evalMode = (activeMode != MODE_RUN) ? activeMode : modeReg;
  assign irqHit   = |(wakeReq & ~swDisable & wakeMask(evalMode));
  assign pendRun  = (modeReg == MODE_RUN);
  assign modEn    = enableMask(activeMode) & ~swDisable;
  assign curMode  = activeMode;

  assert_core_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    activeMode != MODE_RUN |-> modEn[IDX_FLASH:IDX_CORE] == 3'b000);

  assert_stop_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    activeMode == MODE_STOP |-> (modEn & ~STOP_KEEP) == '0);

  assert_cause_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wakeCause));

  assert_cause_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    |wakeCause |=> wakeCause == '0);

  assert_exit_reported_R9: assert property (@(posedge clk) disable iff (!rstN)
    activeMode == MODE_RUN && $past(activeMode) != MODE_RUN |-> wakeCause != '0);

  assert_mode_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    activeMode != MODE_RUN && $past(activeMode) != MODE_RUN |-> $stable(activeMode));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeWrEn,
  input  logic [1:0]          modeWrData,
  input  logic                stopEvt,
  input  logic [12:0]         wakeReq,
  input  logic                rstReq,
  input  logic                bkptIn,
  input  logic [12:0]         swDisable,
  output logic [12:0]         modEn,
  output logic                coreRun,
  output logic [1:0]          curMode,
  output logic [2:0]          wakeCause
);
  ctlStrobe_t strobe;
  logic irqHit;
  logic pendRun;
  logic lowNow;

  pwr_mode_ctl uCtl (
    .clk(clk), .rstN(rstN), .stopEvt(stopEvt), .pendRun(pendRun),
    .irqHit(irqHit), .rstReq(rstReq), .bkptIn(bkptIn),
    .strobe(strobe), .lowNow(lowNow)
  );

  pwr_mode_dp uDp (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .wakeReq(wakeReq), .swDisable(swDisable), .strobe(strobe),
    .irqHit(irqHit), .pendRun(pendRun), .modEn(modEn),
    .curMode(curMode), .wakeCause(wakeCause)
  );

  assign coreRun = !lowNow;
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWrEn = 1'b0;
  logic [1:0] modeWrData = 2'b00;
  logic stopEvt = 1'b0;
  logic [12:0] wakeReq = '0;
  logic rstReq = 1'b0;
  logic bkptIn = 1'b0;
  logic [12:0] swDisable = '0;
  logic [12:0] modEn;
  logic coreRun;
  logic [1:0] curMode;
  logic [2:0] wakeCause;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .stopEvt(stopEvt), .wakeReq(wakeReq), .rstReq(rstReq), .bkptIn(bkptIn),
    .swDisable(swDisable), .modEn(modEn), .coreRun(coreRun),
    .curMode(curMode), .wakeCause(wakeCause)
  );

  function automatic logic [12:0] expEn(logic [1:0] m, logic [12:0] dis);
    logic [12:0] v;
    case (m)
      2'b01, 2'b10: v = 13'h1FF8;
      2'b11:        v = 13'h1C00;
      default:      v = 13'h1FFF;
    endcase
    return v & ~dis;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setMode(logic [1:0] m);
    modeWrEn = 1'b1; modeWrData = m;
    tick();
    modeWrEn = 1'b0;
  endtask

  task automatic enterMode(logic [1:0] m);
    setMode(m);
    stopEvt = 1'b1;
    tick();
    stopEvt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 coreRun", coreRun, 1);
    chk("R1 modEn", modEn, 13'h1FFF);
    chk("R1 curMode", curMode, 0);
    chk("R1 wakeCause", wakeCause, 0);
  endtask

  task automatic t_nullMode();
    enterMode(2'b00);
    chk("R2 null coreRun", coreRun, 1);
    chk("R2 null curMode", curMode, 0);
  endtask

  task automatic t_eachMode();
    for (int m = 1; m < 4; m++) begin
      enterMode(2'(m));
      chk("R2 curMode", curMode, m);
      chk("R2 coreRun low", coreRun, 0);
      chk(m == 3 ? "R4 stop enables" : "R3 doze/wait enables", modEn, expEn(2'(m), '0));
      bkptIn = 1'b1;
      tick();
      bkptIn = 1'b0;
      chk("R7 bkpt exit", coreRun, 1);
      chk("R9 enables restored", modEn, 13'h1FFF);
      chk("R9 cause bkpt", wakeCause, 3'b100);
      tick();
      chk("R9 pulse one cycle", wakeCause, 0);
    end
  endtask

  task automatic t_waitWake();
    int blocked[3] = '{4, 5, 11};
    int allowed[6] = '{3, 6, 7, 8, 9, 10};
    enterMode(2'b10);
    foreach (blocked[i]) begin
      wakeReq = 13'(1 << blocked[i]);
      tick();
      wakeReq = '0;
      chk("R5 non-wake source", coreRun, 0);
    end
    foreach (allowed[i]) begin
      if (i > 0) enterMode(i[0] ? 2'b01 : 2'b10);
      wakeReq = 13'(1 << allowed[i]);
      tick();
      wakeReq = '0;
      chk("R5 wake source", coreRun, 1);
      chk("R9 cause irq", wakeCause, 3'b001);
    end
  endtask

  task automatic t_stopWake();
    enterMode(2'b11);
    wakeReq = 13'h03FB & ~13'h0400;
    tick();
    wakeReq = '0;
    chk("R6 stop ignores peripherals", coreRun, 0);
    chk("R6 stop still stop", curMode, 3);
    wakeReq = 13'h0400;
    tick();
    wakeReq = '0;
    chk("R6 intc wakes stop", coreRun, 1);
    enterMode(2'b11);
    rstReq = 1'b1;
    tick();
    rstReq = 1'b0;
    chk("R6 reset wakes stop", coreRun, 1);
    chk("R9 cause reset", wakeCause, 3'b010);
  endtask

  task automatic t_priority();
    enterMode(2'b10);
    rstReq = 1'b1; bkptIn = 1'b1; wakeReq = 13'h0100;
    tick();
    rstReq = 1'b0; bkptIn = 1'b0; wakeReq = '0;
    chk("R9 reset priority", wakeCause, 3'b010);
    enterMode(2'b01);
    bkptIn = 1'b1; wakeReq = 13'h0100;
    tick();
    bkptIn = 1'b0; wakeReq = '0;
    chk("R9 bkpt over irq", wakeCause, 3'b100);
  endtask

  task automatic t_swDisable();
    swDisable = 13'h0880;
    tick();
    chk("R8 run masked", modEn, expEn(2'b00, 13'h0880));
    enterMode(2'b01);
    chk("R8 doze masked", modEn, expEn(2'b01, 13'h0880));
    wakeReq = 13'h0080;
    tick();
    wakeReq = '0;
    chk("R8 disabled source ignored", coreRun, 0);
    wakeReq = 13'h0040;
    tick();
    wakeReq = '0;
    chk("R8 other source wakes", coreRun, 1);
    chk("R8 restored masked", modEn, expEn(2'b00, 13'h0880));
    swDisable = '0;
  endtask

  task automatic t_sameCycle();
    setMode(2'b11);
    stopEvt = 1'b1; wakeReq = 13'h0400;
    tick();
    stopEvt = 1'b0; wakeReq = '0;
    chk("R10 irq race stays run", coreRun, 1);
    chk("R10 no pulse", wakeCause, 0);
    stopEvt = 1'b1; rstReq = 1'b1;
    tick();
    stopEvt = 1'b0; rstReq = 1'b0;
    chk("R10 reset race stays run", curMode, 0);
  endtask

  task automatic t_modeWrite();
    enterMode(2'b01);
    setMode(2'b11);
    chk("R11 mode held in low", curMode, 1);
    chk("R11 enables held", modEn, expEn(2'b01, '0));
    bkptIn = 1'b1;
    tick();
    bkptIn = 1'b0;
    stopEvt = 1'b1;
    tick();
    stopEvt = 1'b0;
    chk("R11 field retained", curMode, 3);
    rstReq = 1'b1;
    tick();
    rstReq = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    rstN = 1'b1;
    tick();
    t_reset();
    t_nullMode();
    t_eachMode();
    t_waitWake();
    t_stopWake();
    t_priority();
    t_swDisable();
    t_sameCycle();
    t_modeWrite();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule